// File: doc/BRIEF.md
# Serial Host Register Command Interface

This block is the slave end of a byte-oriented serial link through which a host microcontroller reaches a reader's register file and issues direct commands. The serial lines are oversampled by the system clock. Each transaction opens with a control byte. That byte either names a direct command or sets up a register access. A register access is a write or a read. It touches one address or walks forward one address per data byte.

The register file holds a chip status byte, a protocol selection byte, a block of configuration bytes, an interrupt status byte, a collision position byte, a FIFO fill level and a FIFO data port. It drives an interrupt line toward the host. Transactions are framed in one of two ways: by a select line, or by start and stop conditions on the data line while the serial clock is high. The framing is fixed once after reset from three strap pins.

Top module: `hostlink_regif`

## Requirements
- R1: One cycle after reset the strap pins are latched and held. Pattern 001 selects start/stop framing. Patterns 000 and 111 disable the link: traffic is ignored and MISO stays 0. Every other pattern selects select-line framing.
- R2: In the first byte of a transaction, bit 7 = 1 marks a direct command and bit 6 = 1 marks a read. Bit 5 = 1 marks continuous addressing. Bits 4:0 hold the register address or the command code. Bits are taken MSB first on rising SCLK.
- R3: In a single write, the first data byte is stored at the address. Later bytes of the same transaction are ignored.
- R4: In a continuous write, successive data bytes go to successive addresses. The address stops advancing once it reaches the FIFO port 0x1F.
- R5: In a read, MISO shifts the addressed register out MSB first, starting with the byte after the control byte. It changes after falling SCLK edges. A continuous read advances as in R4. A single read returns 0x00 for any further byte.
- R6: With select-line framing, the transaction runs while ss_n is low. A rise of ss_n ends it, and the next transaction starts again with a control byte.
- R7: With start/stop framing, a fall of MOSI while SCLK is high opens a transaction and a rise of MOSI while SCLK is high closes it. Bytes clocked outside a transaction have no effect.
- R8: Writes to 0x1F push into a 12-entry FIFO, and pushes into a full FIFO are dropped. Reads of 0x1F pop the oldest entry and return 0x00 when the FIFO is empty. Register 0x1C reads the fill level.
- R9: Direct command code 0x0F (control byte 0x8F) empties the FIFO and clears the collision register 0x0E. Other command codes change nothing.
- R10: Interrupt status 0x0C is set bitwise by irq_event_i, and irq_o is the OR of its bits. It is cleared by reset, by en_i low, by any write to 0x01, and once it has been read out.
- R11: A write to 0x01 stores the value and zeroes registers 0x02 to 0x0B, except bits 5:4 of 0x09, which keep their value. Register 0x00 is untouched.
- R12: Host writes to 0x0C and 0x1C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Enable; low clears interrupt status |
| mode_pins_i | input | 3 | Framing strap pins, latched once after reset |
| sclk_i | input | 1 | Serial clock from the host |
| ss_n_i | input | 1 | Active-low select (select-line framing only) |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host |
| irq_event_i | input | 8 | Status bits raised by the reader core |
| irq_o | output | 1 | Interrupt request to the host |

## Verification
A wrong bit counter or a wrong control-byte latch shows up in the very next register read: the byte returned on MISO lands at a shifted position or comes from the wrong address, one serial byte after the fault. Address stepping and FIFO pointer faults show up on the following burst read or fill-level read. A wrong interrupt-status clear shows on irq_o within a couple of system cycles of the enable, protocol write or read-out that should have cleared it. Framing faults are exposed by sending traffic that must be ignored and then reading back the registers it could have altered.

// File: rtl/hl_pkg.sv
package hl_pkg;
    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // Addresses whose behaviour is special
    localparam addr_t A_PROTO     = 5'h01;
    localparam addr_t A_CFG_FIRST = 5'h02;
    localparam addr_t A_CLKDIV    = 5'h09;
    localparam addr_t A_CFG_LAST  = 5'h0B;
    localparam addr_t A_IRQ       = 5'h0C;
    localparam addr_t A_COLL      = 5'h0E;
    localparam addr_t A_FLEVEL    = 5'h1C;
    localparam addr_t A_FPORT     = 5'h1F;

    localparam addr_t CMD_FLUSH   = 5'h0F;
    localparam byte_t CLKDIV_KEEP = 8'h30;

    typedef struct packed {
        logic  is_cmd;
        logic  is_read;
        logic  burst;
        addr_t target;
    } ctrl_t;

    typedef enum logic [1:0] {
        LINK_OFF  = 2'd0,
        LINK_SEL  = 2'd1,
        LINK_COND = 2'd2
    } link_e;

    function automatic ctrl_t decode_ctrl(byte_t b);
        return ctrl_t'(b);
    endfunction

    function automatic link_e pick_link(logic [2:0] p);
        if (p == 3'b000 || p == 3'b111) return LINK_OFF;
        if (p == 3'b001) return LINK_COND;
        return LINK_SEL;
    endfunction

    // Burst addressing stops at the FIFO port so a burst streams it
    function automatic addr_t step_addr(addr_t a);
        return (a == A_FPORT) ? a : a + 5'd1;
    endfunction

    function automatic logic host_writable(addr_t a);
        return !(a == A_IRQ || a == A_FLEVEL || a == A_FPORT);
    endfunction
endpackage

// File: rtl/hl_fifo.sv
module hl_fifo #(
    parameter int DEPTH = 12,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LVL_W-1:0] level
);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             full, empty, do_push, do_pop;

    assign full    = (level == FULL_LVL);
    assign empty   = (level == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    p_level_cap_r8: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);
    p_drop_full_r8: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> level == FULL_LVL);
endmodule

// File: rtl/hl_serial_link.sv
module hl_serial_link
    import hl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  link_e link_mode,
    input  logic  sclk_i,
    input  logic  ss_n_i,
    input  logic  mosi_i,
    output logic  miso_o,
    output logic  cmd_valid_o,
    output addr_t cmd_code_o,
    output logic  wr_en_o,
    output addr_t wr_addr_o,
    output byte_t wr_data_o,
    output logic  rd_en_o,
    output addr_t rd_addr_o,
    input  byte_t rd_data_i
);
    logic [SYNC_STAGES-1:0] sclk_sy, ss_sy, mosi_sy;
    logic sclk_s, ss_s, mosi_s, sclk_d, ss_d, mosi_d;

    assign sclk_s = sclk_sy[SYNC_STAGES-1];
    assign ss_s   = ss_sy[SYNC_STAGES-1];
    assign mosi_s = mosi_sy[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_sy <= '0;
            ss_sy   <= '1;
            mosi_sy <= '1;
            sclk_d  <= 1'b0;
            ss_d    <= 1'b1;
            mosi_d  <= 1'b1;
        end else begin
            sclk_sy <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
            ss_sy   <= {ss_sy[SYNC_STAGES-2:0], ss_n_i};
            mosi_sy <= {mosi_sy[SYNC_STAGES-2:0], mosi_i};
            sclk_d  <= sclk_s;
            ss_d    <= ss_s;
            mosi_d  <= mosi_s;
        end
    end

    logic rise, fall, hold_hi, frame_open, frame_close;
    assign rise    = sclk_s & ~sclk_d;
    assign fall    = ~sclk_s & sclk_d;
    assign hold_hi = sclk_s & sclk_d;

    always_comb begin
        frame_open  = 1'b0;
        frame_close = 1'b0;
        case (link_mode)
            LINK_SEL: begin
                frame_open  = ss_d & ~ss_s;
                frame_close = ~ss_d & ss_s;
            end
            LINK_COND: begin
                frame_open  = hold_hi & mosi_d & ~mosi_s;
                frame_close = hold_hi & ~mosi_d & mosi_s;
            end
            default: ;
        endcase
    end

    logic       active, have_ctrl, spent;
    logic [2:0] bitcnt;
    logic [6:0] shreg;
    byte_t      out_sh, rx_byte;
    ctrl_t      ctrl, rx_ctrl;
    addr_t      cur_addr;
    logic       load_slot;

    assign rx_byte   = {shreg, mosi_s};
    assign rx_ctrl   = decode_ctrl(rx_byte);
    assign load_slot = active & fall & have_ctrl & (bitcnt == 3'd0)
                     & ctrl.is_read & ~ctrl.is_cmd;
    assign rd_en_o   = load_slot & ~spent;
    assign rd_addr_o = cur_addr;
    assign miso_o    = (active & have_ctrl & ctrl.is_read & ~ctrl.is_cmd) ? out_sh[7] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            have_ctrl   <= 1'b0;
            spent       <= 1'b0;
            bitcnt      <= '0;
            shreg       <= '0;
            out_sh      <= '0;
            ctrl        <= '0;
            cur_addr    <= '0;
            cmd_valid_o <= 1'b0;
            cmd_code_o  <= '0;
            wr_en_o     <= 1'b0;
            wr_addr_o   <= '0;
            wr_data_o   <= '0;
        end else begin
            cmd_valid_o <= 1'b0;
            wr_en_o     <= 1'b0;
            if (frame_close) begin
                active <= 1'b0;
            end else if (frame_open) begin
                active    <= 1'b1;
                bitcnt    <= '0;
                have_ctrl <= 1'b0;
                spent     <= 1'b0;
                out_sh    <= '0;
            end else if (active) begin
                if (rise) begin
                    shreg  <= rx_byte[6:0];
                    bitcnt <= bitcnt + 3'd1;
                    if (bitcnt == 3'd7) begin
                        if (!have_ctrl) begin
                            have_ctrl   <= 1'b1;
                            ctrl        <= rx_ctrl;
                            cur_addr    <= rx_ctrl.target;
                            cmd_valid_o <= rx_ctrl.is_cmd;
                            cmd_code_o  <= rx_ctrl.target;
                        end else if (!ctrl.is_cmd && !ctrl.is_read && !spent) begin
                            wr_en_o   <= 1'b1;
                            wr_addr_o <= cur_addr;
                            wr_data_o <= rx_byte;
                            if (ctrl.burst) cur_addr <= step_addr(cur_addr);
                            else            spent    <= 1'b1;
                        end
                    end
                end else if (fall) begin
                    if (load_slot) begin
                        if (!spent) begin
                            out_sh <= rd_data_i;
                            if (ctrl.burst) cur_addr <= step_addr(cur_addr);
                            else            spent    <= 1'b1;
                        end else begin
                            out_sh <= '0;
                        end
                    end else begin
                        out_sh <= {out_sh[6:0], 1'b0};
                    end
                end
            end
        end
    end

    p_one_action_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_valid_o, wr_en_o, rd_en_o}));
    p_miso_off_r1: assert property (@(posedge clk) disable iff (rst)
        (link_mode == LINK_OFF) |-> !miso_o);
    p_closed_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        frame_close |=> (!miso_o && !wr_en_o && !cmd_valid_o));
endmodule

// File: rtl/hl_regbank.sv
module hl_regbank
    import hl_pkg::*;
#(
    parameter int FIFO_DEPTH = 12,
    localparam int NREG  = 1 << ADDR_W,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  byte_t irq_event_i,
    input  logic  wr_en,
    input  addr_t wr_addr,
    input  byte_t wr_data,
    input  logic  rd_en,
    input  addr_t rd_addr,
    output byte_t rd_data,
    input  logic  cmd_valid,
    input  addr_t cmd_code,
    output logic  irq_o
);
    byte_t             regs_q [NREG];
    byte_t             irq_q, fifo_dout;
    logic [LVL_W-1:0]  fifo_lvl;
    logic              flush, proto_wr;

    assign flush    = cmd_valid & (cmd_code == CMD_FLUSH);
    assign proto_wr = wr_en & (wr_addr == A_PROTO);
    assign irq_o    = |irq_q;

    hl_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .clr   (flush),
        .push  (wr_en & (wr_addr == A_FPORT)),
        .din   (wr_data),
        .pop   (rd_en & (rd_addr == A_FPORT)),
        .dout  (fifo_dout),
        .level (fifo_lvl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            if (proto_wr) begin
                regs_q[A_PROTO] <= wr_data;
                for (int i = int'(A_CFG_FIRST); i <= int'(A_CFG_LAST); i++)
                    regs_q[i] <= (addr_t'(i) == A_CLKDIV) ? (regs_q[i] & CLKDIV_KEEP) : '0;
            end else if (wr_en && host_writable(wr_addr)) begin
                regs_q[wr_addr] <= wr_data;
            end
            if (flush) regs_q[A_COLL] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en_i || proto_wr)
            irq_q <= '0;
        else
            irq_q <= ((rd_en && rd_addr == A_IRQ) ? '0 : irq_q) | irq_event_i;
    end

    always_comb begin
        case (rd_addr)
            A_IRQ:    rd_data = irq_q;
            A_FLEVEL: rd_data = BYTE_W'(fifo_lvl);
            A_FPORT:  rd_data = fifo_dout;
            default:  rd_data = regs_q[rd_addr];
        endcase
    end

    p_irq_en_r10: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> irq_q == '0);
    p_irq_proto_r10: assert property (@(posedge clk) disable iff (rst)
        proto_wr |=> irq_q == '0);
    p_flush_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> (fifo_lvl == '0 && regs_q[A_COLL] == '0));
    p_div_keep_r11: assert property (@(posedge clk) disable iff (rst)
        proto_wr |=> regs_q[A_CLKDIV][5:4] == $past(regs_q[A_CLKDIV][5:4]));
endmodule

// File: rtl/hostlink_regif.sv
module hostlink_regif
    import hl_pkg::*;
#(
    parameter int FIFO_DEPTH  = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic [2:0] mode_pins_i,
    input  logic       sclk_i,
    input  logic       ss_n_i,
    input  logic       mosi_i,
    output logic       miso_o,
    input  logic [7:0] irq_event_i,
    output logic       irq_o
);
    link_e mode_q;
    logic  mode_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= LINK_OFF;
            mode_done <= 1'b0;
        end else if (!mode_done) begin
            mode_q    <= pick_link(mode_pins_i);
            mode_done <= 1'b1;
        end
    end

    logic  cmd_valid, wr_en, rd_en;
    addr_t cmd_code, wr_addr, rd_addr;
    byte_t wr_data, rd_data;

    hl_serial_link #(.SYNC_STAGES(SYNC_STAGES)) u_link (
        .clk         (clk),
        .rst         (rst),
        .link_mode   (mode_q),
        .sclk_i      (sclk_i),
        .ss_n_i      (ss_n_i),
        .mosi_i      (mosi_i),
        .miso_o      (miso_o),
        .cmd_valid_o (cmd_valid),
        .cmd_code_o  (cmd_code),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .rd_en_o     (rd_en),
        .rd_addr_o   (rd_addr),
        .rd_data_i   (rd_data)
    );

    hl_regbank #(.FIFO_DEPTH(FIFO_DEPTH)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .irq_event_i (irq_event_i),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .cmd_valid   (cmd_valid),
        .cmd_code    (cmd_code),
        .irq_o       (irq_o)
    );

    p_mode_frozen_r1: assert property (@(posedge clk) disable iff (rst)
        mode_done |=> $stable(mode_q));
endmodule

// File: tb/hostlink_regif_tb.sv
module hostlink_regif_tb;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst = 1'b1, en = 1'b1, sclk = 1'b0, ss_n = 1'b1, mosi = 1'b1;
    logic [2:0] pins = 3'b010;
    logic [7:0] irq_ev = '0;
    logic       miso, irq;

    hostlink_regif u_dut (
        .clk(clk), .rst(rst), .en_i(en), .mode_pins_i(pins),
        .sclk_i(sclk), .ss_n_i(ss_n), .mosi_i(mosi), .miso_o(miso),
        .irq_event_i(irq_ev), .irq_o(irq)
    );

    int checks = 0, fails = 0;
    bit noss = 1'b0, finished = 1'b0;

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic do_reset(input logic [2:0] p, input bit cond);
        pins = p; noss = cond; rst = 1'b1;
        sclk = 1'b0; ss_n = 1'b1; mosi = 1'b1;
        ticks(5); rst = 1'b0; ticks(5);
    endtask

    task automatic begin_frame();
        if (noss) begin
            sclk = 1'b1; mosi = 1'b1; ticks(4);
            mosi = 1'b0; ticks(4);
            sclk = 1'b0; ticks(4);
        end else begin
            ss_n = 1'b0; ticks(4);
        end
    endtask

    task automatic end_frame();
        if (noss) begin
            mosi = 1'b0; ticks(4);
            sclk = 1'b1; ticks(4);
            mosi = 1'b1; ticks(6);
            sclk = 1'b0; ticks(4);
        end else begin
            ticks(4); ss_n = 1'b1; ticks(6);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i]; ticks(4);
            rx[i] = miso;
            sclk = 1'b1; ticks(4);
            sclk = 1'b0;
        end
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        logic [7:0] rx;
        begin_frame(); xfer({3'b000, a}, rx); xfer(d, rx); end_frame();
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
        logic [7:0] rx;
        begin_frame(); xfer({3'b010, a}, rx); xfer(8'h00, d); end_frame();
    endtask

    task automatic direct_cmd(input logic [4:0] code);
        logic [7:0] rx;
        begin_frame(); xfer({3'b100, code}, rx); end_frame();
    endtask

    task automatic pulse_event(input logic [7:0] v);
        irq_ev = v; ticks(1); irq_ev = '0; ticks(2);
    endtask

    // {address, value written, value expected on read-back}
    localparam logic [23:0] VEC [6] = '{
        {8'h00, 8'h5A, 8'h5A},
        {8'h02, 8'hC3, 8'hC3},
        {8'h07, 8'h81, 8'h81},
        {8'h0E, 8'h3F, 8'h3F},
        {8'h1C, 8'h55, 8'h00},
        {8'h0C, 8'hFF, 8'h00}
    };

    initial begin
        ticks(190000);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog R1..all actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rd, rx;
        do_reset(3'b010, 1'b0);

        // Reset state (R10, R5)
        check("R10 irq after reset", irq, 1'b0);
        check("R5 miso idle after reset", miso, 1'b0);
        reg_read(5'h0C, rd);
        check("R10 status after reset", rd, 8'h00);

        // Vector table: single write, single read (R2 R3 R12)
        for (int k = 0; k < 6; k++) begin
            reg_write(VEC[k][20:16], VEC[k][15:8]);
            reg_read(VEC[k][20:16], rd);
            check($sformatf("R2 R3 R12 table entry %0d", k), rd, VEC[k][7:0]);
        end

        // R3: extra bytes in a single write are ignored
        begin_frame(); xfer(8'h03, rx); xfer(8'hA1, rx); xfer(8'hB2, rx); end_frame();
        reg_read(5'h03, rd); check("R3 first byte kept", rd, 8'hA1);
        reg_read(5'h04, rd); check("R3 next address untouched", rd, 8'h00);

        // R4 R5: continuous write and read
        begin_frame(); xfer(8'h25, rx);
        for (int j = 0; j < 4; j++) xfer(8'hA0 + 8'(j), rx);
        end_frame();
        begin_frame(); xfer(8'h65, rx);
        for (int j = 0; j < 4; j++) begin
            xfer(8'h00, rd);
            check("R4 R5 burst read", rd, 8'hA0 + 8'(j));
        end
        end_frame();
        begin_frame(); xfer(8'h45, rx); xfer(8'h00, rd); xfer(8'h00, rx); end_frame();
        check("R5 single read first byte", rd, 8'hA0);
        check("R5 single read trailing byte", rx, 8'h00);

        // R4: address holds at the FIFO port
        begin_frame(); xfer(8'h3E, rx); xfer(8'h11, rx); xfer(8'h22, rx); xfer(8'h33, rx); end_frame();
        reg_read(5'h1E, rd); check("R4 burst start address", rd, 8'h11);
        reg_read(5'h1C, rd); check("R4 R8 two bytes pushed", rd, 8'h02);

        // R9: direct commands
        reg_write(5'h0E, 8'h5A);
        direct_cmd(5'h05);
        reg_read(5'h1C, rd); check("R9 other command leaves FIFO", rd, 8'h02);
        direct_cmd(5'h0F);
        reg_read(5'h1C, rd); check("R9 flush empties FIFO", rd, 8'h00);
        reg_read(5'h0E, rd); check("R9 flush clears collision", rd, 8'h00);

        // R8: fill past depth, drain past empty
        begin_frame(); xfer(8'h3F, rx);
        for (int j = 0; j < 14; j++) xfer(8'(j + 1), rx);
        end_frame();
        reg_read(5'h1C, rd); check("R8 level saturates at 12", rd, 8'd12);
        begin_frame(); xfer(8'h7F, rx);
        for (int j = 0; j < 13; j++) begin
            xfer(8'h00, rd);
            check("R8 FIFO order", rd, (j < 12) ? 8'(j + 1) : 8'h00);
        end
        end_frame();
        reg_read(5'h1C, rd); check("R8 level after drain", rd, 8'h00);

        // R10: interrupt status
        pulse_event(8'h24);
        check("R10 irq raised", irq, 1'b1);
        reg_read(5'h0C, rd);
        check("R10 status bits", rd, 8'h24);
        check("R10 cleared after read", irq, 1'b0);
        pulse_event(8'h01);
        reg_write(5'h01, 8'h00);
        check("R10 cleared by protocol write", irq, 1'b0);
        pulse_event(8'h80);
        en = 1'b0; ticks(1); en = 1'b1; ticks(1);
        check("R10 cleared by enable low", irq, 1'b0);

        // R11: protocol write clears configuration
        reg_write(5'h02, 8'hFF);
        reg_write(5'h09, 8'hFF);
        reg_write(5'h0B, 8'h77);
        reg_write(5'h00, 8'h21);
        reg_write(5'h01, 8'h03);
        reg_read(5'h02, rd); check("R11 cfg 0x02 cleared", rd, 8'h00);
        reg_read(5'h09, rd); check("R11 divider bits kept", rd, 8'h30);
        reg_read(5'h0B, rd); check("R11 cfg 0x0B cleared", rd, 8'h00);
        reg_read(5'h00, rd); check("R11 chip status kept", rd, 8'h21);
        reg_read(5'h01, rd); check("R11 protocol value", rd, 8'h03);

        // R6: select rise ends the transaction
        begin_frame(); xfer(8'h0A, rx); end_frame();
        begin_frame(); xfer(8'h5C, rx); xfer(8'h99, rx); end_frame();
        reg_read(5'h0A, rd); check("R6 new frame needs control byte", rd, 8'h00);

        // R7: start/stop framing
        do_reset(3'b001, 1'b1);
        reg_write(5'h04, 8'h3C);
        reg_read(5'h04, rd); check("R7 framed write/read", rd, 8'h3C);
        xfer(8'h04, rx); xfer(8'h99, rx); ticks(8);
        reg_read(5'h04, rd); check("R7 unframed bytes ignored", rd, 8'h3C);

        // R1: disabled link ignores traffic
        do_reset(3'b111, 1'b0);
        pulse_event(8'h81);
        reg_read(5'h0C, rd);
        check("R1 disabled link miso low", rd, 8'h00);
        check("R1 disabled link no read side effect", irq, 1'b1);
        do_reset(3'b110, 1'b0);
        reg_write(5'h05, 8'h6D);
        reg_read(5'h05, rd); check("R1 select framing from 110", rd, 8'h6D);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule